// File: doc/BRIEF.md
# Full-Duplex Auxiliary PCM Serial Port

This block connects a processor core to an external serial codec. Through it the core writes and reads framed stereo samples directly, without any DMA. The port derives a bit clock and a left/right frame clock from its master clock. In every frame it shifts one stereo pair out on a serial output and captures one stereo pair from a serial input, so playback and capture share the same frame clock.

The core loads the next left and right output words into two holding registers at any time during a frame. At each frame boundary the port moves those words into its shifters, copies the words captured during the frame into two receive registers, and pulses `frame_done` for one clock. The number of bit clocks per frame is set at run time by a two-bit ratio field, and a new setting takes effect at the next frame boundary.

Samples are sent MSB first and left-justified in each half frame. Slots beyond the sample width carry zeros on output and are ignored on input.

Top module: `aux_pcm_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared: `bclk`, `lrclk`, `sdout`, `frame_done`, `rx_left` and `rx_right` read 0, the ratio field reads 00, and both output holding words are zero.
- R2: `bclk` toggles once every `DIV_HALF` clock cycles, so one bit period is 2*`DIV_HALF` clocks.
- R3: The ratio field sets the frame length in bit clocks: 00 gives 32, 01 gives 64, 10 gives 128 and 11 gives 64.
- R4: A ratio written during a frame leaves the length of that frame unchanged and applies from the next frame.
- R5: `lrclk` is low for the first half of the frame (left channel) and high for the second half (right channel), and it changes only when `bclk` falls.
- R6: In each half frame, `sdout` carries the channel's sample MSB first in the first `SAMPLE_W` slots and 0 in the remaining slots. It changes only on a falling `bclk`.
- R7: `sdin` is sampled on the rising `bclk`. Slot k of a half frame, for k < `SAMPLE_W`, becomes bit `SAMPLE_W`-1-k of that channel's captured word, and later slots are ignored.
- R8: `frame_done` is high for exactly one clock, at the edge where `bclk` falls to end the last bit of a frame.
- R9: At `frame_done`, `rx_left` and `rx_right` take the words captured during the frame that just ended. They hold their value at all other times.
- R10: The output holding words are moved into the shifters only at `frame_done`. A write to a holding word during a frame does not change that frame's serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the ratio field |
| ctl_ratio | input | 2 | Ratio field value (bits 1:0 of the control register) |
| wr_left | input | 1 | Write strobe for the left output holding word |
| wr_right | input | 1 | Write strobe for the right output holding word |
| wr_data | input | SAMPLE_W | Output sample data for the holding words |
| rx_left | output | SAMPLE_W | Left word captured in the last completed frame |
| rx_right | output | SAMPLE_W | Right word captured in the last completed frame |
| frame_done | output | 1 | One-clock pulse at each frame boundary |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Frame clock, low = left, high = right |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |

## Verification
The hardest situation to reach is a ratio change that arrives in the middle of a frame while output words are also being replaced. A wrong design could then apply the new length or the new words one frame early, and a slip of one bit would change both the frame length and the slot alignment. The bench acts as the serial partner. It follows every bit with its own frame model, and in the first frames it writes all four ratio codes and extreme sample words at fixed bit positions within the frame. After that it applies random writes and random input bits, so frames of different lengths follow one another with live data in both directions.

// File: rtl/pcm_port_pkg.sv
// Shared types and helpers for the auxiliary PCM port.
// Assumes the longest frame is 128 bit clocks.
package pcm_port_pkg;

    localparam int CNT_W = 7;

    typedef enum logic [1:0] {
        RATIO_32  = 2'b00,
        RATIO_64  = 2'b01,
        RATIO_128 = 2'b10,
        RATIO_ALT = 2'b11
    } ratio_e;

    // Index of the last bit of a frame for a given ratio code.
    function automatic logic [CNT_W-1:0] last_bit_of(input logic [1:0] sel);
        case (ratio_e'(sel))
            RATIO_32:  last_bit_of = CNT_W'(31);
            RATIO_128: last_bit_of = CNT_W'(127);
            default:   last_bit_of = CNT_W'(63);
        endcase
    endfunction

endpackage

// File: rtl/pcm_bclk_gen.sv
// Bit clock generator: divides the master clock so that bclk toggles every
// DIV_HALF cycles. It also gives one-cycle strobes that mark the edges where
// bclk rises or falls. Assumes DIV_HALF >= 2.
module pcm_bclk_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DW-1:0] div_q;
    logic          toggle;

    always_comb begin
        toggle   = (div_q == DW'(DIV_HALF - 1));
        rise_evt = toggle & ~bclk;
        fall_evt = toggle & bclk;
    end

    // Divider count and bit clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            bclk  <= 1'b0;
        end else if (toggle) begin
            div_q <= '0;
            bclk  <= ~bclk;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end
endmodule

// File: rtl/pcm_frame_seq.sv
// Frame sequencer: counts bit positions within a frame on falling bclk
// strobes and drives lrclk. It works out the slot of the current and the
// next bit, and marks the frame boundary. The ratio is taken only at a
// boundary. Assumes fall_evt is a one-cycle strobe.
module pcm_frame_seq
    import pcm_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_evt,
    input  logic [1:0]       ratio_sel,
    output logic             lrclk,
    output logic             nxt_lr,
    output logic [CNT_W-1:0] cur_slot,
    output logic [CNT_W-1:0] nxt_slot,
    output logic             frame_end,
    output logic             frame_done
);
    logic [CNT_W-1:0] idx_q, idx_inc, last, half;
    logic [1:0]       act_q;
    logic             at_last;

    // Position decode for the current and the next bit.
    always_comb begin
        last      = last_bit_of(act_q);
        half      = (last >> 1) + CNT_W'(1);
        idx_inc   = idx_q + CNT_W'(1);
        at_last   = (idx_q == last);
        frame_end = fall_evt & at_last;
        nxt_lr    = !at_last && (idx_inc >= half);
        nxt_slot  = at_last ? '0 : (nxt_lr ? idx_inc - half : idx_inc);
        cur_slot  = lrclk ? idx_q - half : idx_q;
    end

    // Bit index, frame clock, active ratio and boundary strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            lrclk      <= 1'b0;
            act_q      <= 2'b00;
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_end;
            if (fall_evt) begin
                idx_q <= at_last ? '0 : idx_inc;
                lrclk <= nxt_lr;
                if (at_last) act_q <= ratio_sel;
            end
        end
    end
endmodule

// File: rtl/pcm_shifter.sv
// Data path: holds the core's next output words, shifts the active words
// out MSB first on falling bclk, and captures input bits on rising bclk.
// At the frame boundary it hands the captured words to the core.
// Assumes SAMPLE_W <= 16 (the shortest half frame).
module pcm_shifter
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_evt,
    input  logic                fall_evt,
    input  logic                frame_end,
    input  logic                lrclk,
    input  logic                nxt_lr,
    input  logic [CNT_W-1:0]    cur_slot,
    input  logic [CNT_W-1:0]    nxt_slot,
    input  logic                sdin,
    input  logic                wr_left,
    input  logic                wr_right,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic                sdout,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right
);
    localparam int IW = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

    logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r, cap_l, cap_r, tx_word;
    logic [IW-1:0]       tx_pos, cap_pos;
    logic                tx_bit, cap_ok;

    // Select the bit to present after the coming falling edge.
    always_comb begin
        tx_word = frame_end ? hold_l : (nxt_lr ? act_r : act_l);
        tx_pos  = IW'(SAMPLE_W - 1) - IW'(nxt_slot);
        tx_bit  = (nxt_slot < CNT_W'(SAMPLE_W)) ? tx_word[tx_pos] : 1'b0;
        cap_pos = IW'(SAMPLE_W - 1) - IW'(cur_slot);
        cap_ok  = (cur_slot < CNT_W'(SAMPLE_W));
    end

    // Holding words written by the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else begin
            if (wr_left)  hold_l <= wr_data;
            if (wr_right) hold_r <= wr_data;
        end
    end

    // Active output words and serial output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
            sdout <= 1'b0;
        end else if (fall_evt) begin
            sdout <= tx_bit;
            if (frame_end) begin
                act_l <= hold_l;
                act_r <= hold_r;
            end
        end
    end

    // Input capture and the hand-over of captured words at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_l    <= '0;
            cap_r    <= '0;
            rx_left  <= '0;
            rx_right <= '0;
        end else begin
            if (rise_evt && cap_ok) begin
                if (lrclk) cap_r[cap_pos] <= sdin;
                else       cap_l[cap_pos] <= sdin;
            end
            if (frame_end) begin
                rx_left  <= cap_l;
                rx_right <= cap_r;
            end
        end
    end
endmodule

// File: rtl/aux_pcm_port.sv
// Top of the auxiliary PCM port: the ratio control field, the bit clock
// generator, the frame sequencer and the data path. Assumes the master
// clock is 2*DIV_HALF times the wanted bit rate.
module aux_pcm_port
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DIV_HALF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [1:0]          ctl_ratio,
    input  logic                wr_left,
    input  logic                wr_right,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                frame_done,
    output logic                bclk,
    output logic                lrclk,
    output logic                sdout,
    input  logic                sdin
);
    logic             rise_evt, fall_evt, frame_end, nxt_lr;
    logic [CNT_W-1:0] cur_slot, nxt_slot;
    logic [1:0]       ratio_q;

    // Ratio field of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ratio_q <= 2'b00;
        else if (ctl_we) ratio_q <= ctl_ratio;
    end

    pcm_bclk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    pcm_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_evt   (fall_evt),
        .ratio_sel  (ratio_q),
        .lrclk      (lrclk),
        .nxt_lr     (nxt_lr),
        .cur_slot   (cur_slot),
        .nxt_slot   (nxt_slot),
        .frame_end  (frame_end),
        .frame_done (frame_done)
    );

    pcm_shifter #(.SAMPLE_W(SAMPLE_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .frame_end (frame_end),
        .lrclk     (lrclk),
        .nxt_lr    (nxt_lr),
        .cur_slot  (cur_slot),
        .nxt_slot  (nxt_slot),
        .sdin      (sdin),
        .wr_left   (wr_left),
        .wr_right  (wr_right),
        .wr_data   (wr_data),
        .sdout     (sdout),
        .rx_left   (rx_left),
        .rx_right  (rx_right)
    );
endmodule

// File: rtl/aux_pcm_port_chk.sv
// Checker for aux_pcm_port: the port-level timing rules of the serial side
// and the boundary strobe. It is bound to every instance of the top module.
module aux_pcm_port_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_done,
    input logic                bclk,
    input logic                lrclk,
    input logic                sdout,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right
);
    // R8: the boundary strobe sits on a falling bit clock
    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!bclk && $past(bclk)));

    // R8: the boundary strobe lasts one clock
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9: the receive words change only at the boundary
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> ($stable(rx_left) && $stable(rx_right)));

    // R5: the frame clock moves only when the bit clock falls
    a_r5_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> (!bclk && $past(bclk)));

    // R6: serial output moves only when the bit clock falls
    a_r6_sdout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> (!bclk && $past(bclk)));
endmodule

bind aux_pcm_port aux_pcm_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .bclk       (bclk),
    .lrclk      (lrclk),
    .sdout      (sdout),
    .rx_left    (rx_left),
    .rx_right   (rx_right)
);

// File: tb/aux_pcm_port_tb.sv
module aux_pcm_port_tb;
    localparam int SW = 16;
    localparam int DH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0, wr_left = 1'b0, wr_right = 1'b0, sdin = 1'b0;
    logic [1:0]    ctl_ratio = 2'b00;
    logic [SW-1:0] wr_data = '0;
    logic [SW-1:0] rx_left, rx_right;
    logic          frame_done, bclk, lrclk, sdout;

    int checks = 0, errors = 0;
    bit done = 0;

    aux_pcm_port #(.SAMPLE_W(SW), .DIV_HALF(DH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_ratio(ctl_ratio),
        .wr_left(wr_left), .wr_right(wr_right), .wr_data(wr_data),
        .rx_left(rx_left), .rx_right(rx_right), .frame_done(frame_done),
        .bclk(bclk), .lrclk(lrclk), .sdout(sdout), .sdin(sdin)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int frame_len(input logic [1:0] s);
        case (s)
            2'b00: return 32;
            2'b10: return 128;
            default: return 64;
        endcase
    endfunction

    function automatic logic exp_bit(input int i, input int n, input logic [SW-1:0] l, input logic [SW-1:0] r);
        int h = n / 2;
        int slot = (i < h) ? i : i - h;
        logic [SW-1:0] w = (i < h) ? l : r;
        return (slot < SW) ? w[SW-1-slot] : 1'b0;
    endfunction

    initial begin
        logic [SW-1:0] hold_l = '0, hold_r = '0, act_l = '0, act_r = '0;
        logic [SW-1:0] cap_l = '0, cap_r = '0, exp_l = '0, exp_r = '0;
        logic [1:0]    ctl_m = 2'b00;
        int idx = 0, n_bits = 32, frames = 0, since = 0;
        bit prev_b = 0, seen_toggle = 0;
        void'($urandom(32'h5eed_1234));

        repeat (4) @(negedge clk);
        // R1: state under reset
        check(bclk == 0 && lrclk == 0 && sdout == 0 && frame_done == 0, "R1 serial",
              {bclk, lrclk, sdout, frame_done}, 0);
        check(rx_left == 0 && rx_right == 0, "R1 rx", {rx_left, rx_right}, 0);
        rst_n = 1'b1;
        begin
            logic b0 = 1'($urandom % 2);
            sdin = b0;
            cap_l[SW-1] = b0;
        end

        while (frames < 40) begin
            logic b;
            @(negedge clk);
            wr_left = 0; wr_right = 0; ctl_we = 0;
            b = bclk;
            since++;
            if (b != prev_b) begin
                // R2: toggle spacing
                if (seen_toggle) check(since == DH, "R2 bclk spacing", since, DH);
                seen_toggle = 1;
                since = 0;
            end
            if (b && !prev_b) begin
                // R6 output bit, R5 channel level
                check(sdout == exp_bit(idx, n_bits, act_l, act_r), "R6 sdout",
                      sdout, exp_bit(idx, n_bits, act_l, act_r));
                check(lrclk == (idx >= n_bits / 2), "R5 lrclk", lrclk, (idx >= n_bits / 2));
                check(frame_done == 0, "R8 idle", frame_done, 0);
                // R10 / R4: core writes mid-frame, directed first then random
                if (idx == 1 || idx == 2) begin
                    logic [SW-1:0] d;
                    case (frames)
                        0: d = (idx == 1) ? 16'hFFFF : 16'h8001;
                        1: d = (idx == 1) ? 16'h0001 : 16'hA5A5;
                        2: d = (idx == 1) ? 16'h8000 : 16'h7FFF;
                        default: d = SW'($urandom);
                    endcase
                    wr_data = d;
                    if (idx == 1) begin wr_left = 1; hold_l = d; end
                    else begin wr_right = 1; hold_r = d; end
                end else if (idx == 3) begin
                    logic [1:0] c;
                    bit go = 1;
                    case (frames)
                        0: c = 2'b11;
                        1: c = 2'b10;
                        2: c = 2'b01;
                        3: c = 2'b00;
                        default: begin c = 2'($urandom); go = ($urandom % 3) == 0; end
                    endcase
                    if (go) begin
                        ctl_we = 1; ctl_ratio = c; ctl_m = c;
                    end
                end
            end else if (!b && prev_b) begin
                int h, slot;
                logic nb;
                idx = (idx == n_bits - 1) ? 0 : idx + 1;
                if (idx == 0) begin
                    // R8 boundary strobe; R3 R4 frame length follows ratio model
                    check(frame_done == 1, "R8 R3 R4 boundary", frame_done, 1);
                    exp_l = cap_l; exp_r = cap_r;
                    act_l = hold_l; act_r = hold_r;
                    n_bits = frame_len(ctl_m);
                    frames++;
                end else begin
                    check(frame_done == 0, "R8 R3 R4 mid-frame", frame_done, 0);
                end
                // R9 / R7: captured words handed over
                check(rx_left == exp_l, "R9 R7 rx_left", rx_left, exp_l);
                check(rx_right == exp_r, "R9 R7 rx_right", rx_right, exp_r);
                // R7: drive the next input bit
                h = n_bits / 2;
                slot = (idx < h) ? idx : idx - h;
                nb = 1'($urandom % 2);
                sdin = nb;
                if (slot < SW) begin
                    if (idx < h) cap_l[SW-1-slot] = nb;
                    else         cap_r[SW-1-slot] = nb;
                end
            end else begin
                check(frame_done == 0, "R8 quiet", frame_done, 0);
            end
            prev_b = b;
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule